// File: doc/BRIEF.md
# Rectangle Fill Bit-Plane Memory with Serial Video Output

This block models one bit plane of a 64 by 64 display memory whose native write operation fills an axis-aligned rectangle. A cell takes part in a write only when its row lies inside a selected row band and its column lies inside a selected column band. Every such cell receives the same data bit on one clock edge, so a box of any size costs one write cycle.

Rectangle bounds arrive over a 12-bit address port in two beats. The first beat carries the row band and the second carries the column band. A single band decoder serves both beats, and its outputs are captured into row-select and column-select registers. The operation runs on the clock edge after the second beat.

Reads are allowed only when the row band is exactly one row wide. A read copies the whole row into a 64-bit holding latch. Later, a load request moves the latch into a 64-bit shift register, which sends the row out one bit per pixel enable as a video stream. Because of the latch, the row read does not need to be timed against the video scan.

Top module: `rect_fill_ram`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `video_out`, `video_busy`, `rd_done` and `rd_reject` are all 0, and the holding latch reads as all zeros.
- R2: Address beats alternate, starting with a row beat after reset. On each beat, `addr_in[11:6]` is the lower bound and `addr_in[5:0]` is the upper bound. `op_write` and `wr_bit` are sampled with the second beat, which is the column beat. The operation executes on the following clock edge, so `rd_done` or `rd_reject` is high during the cycle that starts two edges after the second beat is driven.
- R3: A write (`op_write`=1) stores `wr_bit` into every cell whose row r and column c satisfy row_lo <= r <= row_hi and col_lo <= c <= col_hi. All other cells keep their contents. A band whose lower bound exceeds its upper bound selects nothing, so the write changes no cell.
- R4: A read (`op_write`=0) whose row band is exactly one row copies that row into the holding latch, with column c at latch bit c. It raises `rd_done` for exactly one cycle. The column bounds of a read are ignored.
- R5: A read whose row band is not exactly one row is rejected. This covers a band of several rows and an empty band. `rd_reject` is high for one cycle, `rd_done` stays low, and the latch is unchanged.
- R6: A load request while the shifter is idle copies the latch into the shifter on that edge. `video_busy` rises, and `video_out` shows latch bit 63 first. Each later pixel enable advances to the next lower bit.
- R7: While busy, a cycle without `pix_en` holds `video_out` and `video_busy`. After the 64th enabled shift, `video_busy` falls and `video_out` is 0. `pix_en` while idle has no effect.
- R8: A load request made while busy is remembered. On the edge that shifts out the last bit, the shifter reloads from the latch instead of going idle, with no gap in the stream.
- R9: Once loaded, the shifter contents are independent of the latch. A read executed during shifting changes only what a later load will send.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | Marks an address beat |
| addr_in | input | 12 | Band bounds: lower in [11:6], upper in [5:0] |
| op_write | input | 1 | With the column beat: 1 for rectangle write, 0 for row read |
| wr_bit | input | 1 | Fill value, sampled with the column beat |
| load_req | input | 1 | Request to move the latch into the video shifter |
| pix_en | input | 1 | Pixel enable; shifts one bit while busy |
| rd_done | output | 1 | One-cycle pulse: row read accepted |
| rd_reject | output | 1 | One-cycle pulse: read band was not a single row |
| video_out | output | 1 | Serial video bit, MSB first |
| video_busy | output | 1 | Shifter holds a word still being sent |

## Verification
The hardest case to reach is a reload at the word boundary while the latch has been changed mid-stream. The stimulus first loads one row and shifts part of it. It then runs a read of a different row while the shifter is paused, and issues a load request that has to wait. After that it keeps `pix_en` high across the boundary, so any gap, early transfer or use of stale latch data misaligns the expected bit queue. Empty bands on both axes and multi-row reads are streamed back through the video port to show that cells and latch are untouched.

// File: rtl/rfr_pkg.sv
package rfr_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } rfr_op_e;
endpackage

// File: rtl/band_decoder.sv
// Selects every output whose index lies in [lo, hi]; empty when lo > hi.
module band_decoder #(
  parameter int N  = 64,
  parameter int AW = $clog2(N)
) (
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic [N-1:0]  sel
);
  for (genvar i = 0; i < N; i++) begin : g_line
    localparam logic [AW-1:0] IDX = AW'(i);
    assign sel[i] = (lo <= IDX) && (IDX <= hi);
  end
endmodule

// File: rtl/cell_array.sv
// Bit-plane storage: band-crossing rectangle write, single-row read into latch.
module cell_array #(
  parameter int ROWS = 64,
  parameter int COLS = 64,
  parameter int RAW  = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [ROWS-1:0] row_sel,
  input  logic [COLS-1:0] col_sel,
  input  logic            wr_bit,
  input  logic            rd_en,
  input  logic [RAW-1:0]  rd_row,
  output logic [COLS-1:0] row_latch
);
  logic [COLS-1:0] mem [ROWS];

  // R3: every selected row merges the column band with the fill value
  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (wr_en && row_sel[r]) begin
        mem[r] <= wr_bit ? (mem[r] | col_sel) : (mem[r] & ~col_sel);
      end
    end
  end

  // R4/R5: latch changes only on an accepted single-row read
  always_ff @(posedge clk) begin
    if (rst) begin
      row_latch <= '0;
    end else if (rd_en) begin
      row_latch <= mem[rd_row];
    end
  end
endmodule

// File: rtl/video_shifter.sv
// MSB-first serialiser; load requests during a word wait for its last bit.
module video_shifter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_req,
  input  logic         pix_en,
  input  logic [W-1:0] din,
  output logic         dout,
  output logic         busy
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sr;
  logic [CW-1:0] cnt;
  logic          pend;
  logic          want;

  assign want = load_req | pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      pend <= 1'b0;
    end else if (!busy) begin
      // R6: idle load happens at once
      if (want) begin
        sr   <= din;
        cnt  <= '0;
        busy <= 1'b1;
        pend <= 1'b0;
      end
    end else if (pix_en) begin
      if (cnt == LAST) begin
        if (want) begin
          // R8: reload at the word boundary, no idle slot
          sr   <= din;
          cnt  <= '0;
          pend <= 1'b0;
        end else begin
          // R7: word finished
          sr   <= '0;
          cnt  <= '0;
          busy <= 1'b0;
        end
      end else begin
        sr   <= {sr[W-2:0], 1'b0};
        cnt  <= cnt + 1'b1;
        pend <= want;
      end
    end else begin
      pend <= want;
    end
  end

  assign dout = sr[W-1];
endmodule

// File: rtl/rect_fill_ram.sv
module rect_fill_ram #(
  parameter int ROWS = 64,
  parameter int COLS = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        addr_valid,
  input  logic [11:0] addr_in,
  input  logic        op_write,
  input  logic        wr_bit,
  input  logic        load_req,
  input  logic        pix_en,
  output logic        rd_done,
  output logic        rd_reject,
  output logic        video_out,
  output logic        video_busy
);
  import rfr_pkg::*;

  localparam int AW = $clog2(ROWS);
  localparam int N  = (ROWS > COLS) ? ROWS : COLS;

  logic            col_phase;
  logic [N-1:0]    band;
  logic [ROWS-1:0] row_sel_q;
  logic [AW-1:0]   row_lo_q;
  logic [COLS-1:0] col_sel_q;
  logic            exec_q;
  rfr_op_e         op_q;
  logic            bit_q;
  logic            one_row;
  logic            wr_go;
  logic            rd_go;
  logic [COLS-1:0] row_latch;

  // One decoder, shared by the row beat and the column beat
  band_decoder #(.N(N), .AW(AW)) u_dec (
    .lo  (addr_in[2*AW-1:AW]),
    .hi  (addr_in[AW-1:0]),
    .sel (band)
  );

  // R2: beat sequencing and select latching
  always_ff @(posedge clk) begin
    if (rst) begin
      col_phase <= 1'b0;
      row_sel_q <= '0;
      row_lo_q  <= '0;
      col_sel_q <= '0;
      exec_q    <= 1'b0;
      op_q      <= OP_READ;
      bit_q     <= 1'b0;
    end else begin
      exec_q <= 1'b0;
      if (addr_valid) begin
        col_phase <= ~col_phase;
        if (!col_phase) begin
          row_sel_q <= band[ROWS-1:0];
          row_lo_q  <= addr_in[2*AW-1:AW];
        end else begin
          col_sel_q <= band[COLS-1:0];
          op_q      <= op_write ? OP_WRITE : OP_READ;
          bit_q     <= wr_bit;
          exec_q    <= 1'b1;
        end
      end
    end
  end

  // R4/R5: a read needs exactly one active row line
  assign one_row = (row_sel_q != '0) &&
                   ((row_sel_q & (row_sel_q - ROWS'(1))) == '0);
  assign wr_go   = exec_q && (op_q == OP_WRITE);
  assign rd_go   = exec_q && (op_q == OP_READ) && one_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_done   <= 1'b0;
      rd_reject <= 1'b0;
    end else begin
      rd_done   <= rd_go;
      rd_reject <= exec_q && (op_q == OP_READ) && !one_row;
    end
  end

  cell_array #(.ROWS(ROWS), .COLS(COLS), .RAW(AW)) u_cells (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_go),
    .row_sel   (row_sel_q),
    .col_sel   (col_sel_q),
    .wr_bit    (bit_q),
    .rd_en     (rd_go),
    .rd_row    (row_lo_q),
    .row_latch (row_latch)
  );

  video_shifter #(.W(COLS)) u_vid (
    .clk      (clk),
    .rst      (rst),
    .load_req (load_req),
    .pix_en   (pix_en),
    .din      (row_latch),
    .dout     (video_out),
    .busy     (video_busy)
  );
endmodule

// File: rtl/rect_fill_ram_sva.sv
module rect_fill_ram_sva (
  input logic clk,
  input logic rst,
  input logic addr_valid,
  input logic pix_en,
  input logic load_req,
  input logic rd_done,
  input logic rd_reject,
  input logic video_out,
  input logic video_busy
);
  AST_DONE_XOR_REJECT: assert property (@(posedge clk) disable iff (rst)
    !(rd_done && rd_reject)); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done); // R4

  AST_RESULT_AFTER_BEAT: assert property (@(posedge clk) disable iff (rst)
    (rd_done || rd_reject) |-> $past(addr_valid, 2)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !video_busy |-> !video_out); // R7

  AST_HOLD_NO_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (video_busy && !pix_en) |=> (video_busy && $stable(video_out))); // R7

  AST_IDLE_NO_LOAD_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!video_busy && !load_req && !$past(video_busy)) |=> !video_busy); // R6
endmodule

bind rect_fill_ram rect_fill_ram_sva u_sva (
  .clk        (clk),
  .rst        (rst),
  .addr_valid (addr_valid),
  .pix_en     (pix_en),
  .load_req   (load_req),
  .rd_done    (rd_done),
  .rd_reject  (rd_reject),
  .video_out  (video_out),
  .video_busy (video_busy)
);

// File: tb/rect_fill_ram_tb.sv
`timescale 1ns/100ps
module rect_fill_ram_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr_valid = 1'b0;
  logic [11:0] addr_in = '0;
  logic        op_write = 1'b0;
  logic        wr_bit = 1'b0;
  logic        load_req = 1'b0;
  logic        pix_en = 1'b0;
  logic        rd_done, rd_reject, video_out, video_busy;

  int checks = 0;
  int errors = 0;

  bit [63:0] mm [64];
  bit [63:0] m_latch = '0;
  bit        evq [$];   // 1 = accepted read, 0 = rejected read
  bit        vq  [$];   // expected serial bits

  always #2.5 clk = ~clk;

  rect_fill_ram u_dut (
    .clk(clk), .rst(rst), .addr_valid(addr_valid), .addr_in(addr_in),
    .op_write(op_write), .wr_bit(wr_bit), .load_req(load_req), .pix_en(pix_en),
    .rd_done(rd_done), .rd_reject(rd_reject), .video_out(video_out),
    .video_busy(video_busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_done || rd_reject) begin
        if (evq.size() == 0) chk(0, "R4/R5 unexpected read result", int'(rd_done), 0);
        else begin
          bit e;
          e = evq.pop_front();
          chk(rd_done == e && rd_reject == !e, "R4/R5 read result", int'(rd_done), int'(e));
        end
      end
      if (video_busy && pix_en) begin
        if (vq.size() == 0) chk(0, "R6/R7 extra video bit", int'(video_out), 0);
        else begin
          bit b;
          b = vq.pop_front();
          chk(video_out == b, "R3/R6/R8 video bit", int'(video_out), int'(b));
        end
      end
    end
  end

  task automatic beat(input int lo, input int hi, input bit wr, input bit d);
    addr_valid = 1'b1;
    addr_in    = {6'(lo), 6'(hi)};
    op_write   = wr;
    wr_bit     = d;
    @(posedge clk); #1;
    addr_valid = 1'b0;
    op_write   = 1'b0;
    wr_bit     = 1'b0;
  endtask

  // R3: rectangle write plus reference update
  task automatic do_write(input int rl, input int rh, input int cl, input int ch, input bit d);
    beat(rl, rh, 1'b0, 1'b0);
    beat(cl, ch, 1'b1, d);
    for (int r = rl; r <= rh; r++)
      for (int c = cl; c <= ch; c++) mm[r][c] = d;
    @(posedge clk); #1;
  endtask

  // R4/R5: row read; driver pushes the expected result
  task automatic do_read(input int rl, input int rh);
    beat(rl, rh, 1'b0, 1'b0);
    beat(0, 63, 1'b0, 1'b0);
    if (rl == rh) begin
      m_latch = mm[rl];
      evq.push_back(1'b1);
    end else evq.push_back(1'b0);
    @(posedge clk); #1;
  endtask

  task automatic do_load();
    load_req = 1'b1;
    for (int b = 63; b >= 0; b--) vq.push_back(m_latch[b]);
    @(posedge clk); #1;
    load_req = 1'b0;
  endtask

  task automatic run_pix(input int n);
    pix_en = 1'b1;
    repeat (n) @(posedge clk);
    #1 pix_en = 1'b0;
  endtask

  task automatic stream_check(input string req);
    do_load();
    run_pix(64);
    chk(vq.size() == 0, req, vq.size(), 0);
    chk(!video_busy && !video_out, "R7 idle after word", int'(video_busy), 0);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs during reset
    chk(!video_out && !video_busy && !rd_done && !rd_reject, "R1 reset outputs",
        int'({video_out, video_busy, rd_done, rd_reject}), 0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk(!video_out && !video_busy && !rd_done && !rd_reject, "R1 after reset",
        int'({video_out, video_busy, rd_done, rd_reject}), 0);
    // R1: latch is zero after reset
    stream_check("R1 latch clear");

    // R3: fill patterns
    do_write(0, 63, 0, 63, 1'b0);
    do_write(2, 5, 10, 20, 1'b1);
    do_write(4, 4, 0, 63, 1'b1);
    do_write(3, 8, 15, 15, 1'b0);
    do_write(63, 63, 63, 63, 1'b1);
    do_write(0, 0, 0, 0, 1'b1);
    do_write(20, 19, 0, 63, 1'b1);   // empty row band
    for (int r = 0; r < 64; r++) mm[r] = mm[r];
    beat(0, 63, 1'b0, 1'b0);         // empty column band
    beat(40, 39, 1'b1, 1'b1);
    @(posedge clk); #1;

    // R2: result timing of a row read
    beat(3, 3, 1'b0, 1'b0);
    addr_valid = 1'b1; addr_in = {6'd50, 6'd1}; op_write = 1'b0;
    @(posedge clk); #1;
    addr_valid = 1'b0;
    chk(!rd_done, "R2 no early result", int'(rd_done), 0);
    m_latch = mm[3];
    evq.push_back(1'b1);
    @(posedge clk); #1;
    chk(rd_done, "R2 result one edge after column beat", int'(rd_done), 1);
    @(posedge clk); #1;
    chk(!rd_done, "R4 single pulse", int'(rd_done), 0);
    stream_check("R4 row 3");

    do_read(4, 4);   stream_check("R3 full row 4");
    do_read(63, 63); stream_check("R3 corner row 63");
    do_read(0, 0);   stream_check("R3 corner row 0");
    do_read(20, 20); stream_check("R3 empty band row 20");
    do_read(2, 2);   stream_check("R3 row 2");
    do_read(8, 8);   stream_check("R3 row 8");

    // R5: rejected reads leave the latch as it was
    do_read(5, 7);   stream_check("R5 multi-row reject");
    do_read(9, 8);   stream_check("R5 empty-band reject");
    chk(evq.size() == 0, "R5 all results seen", evq.size(), 0);

    // R7: pix_en while idle does nothing
    run_pix(5);
    chk(!video_busy && !video_out, "R7 idle enable ignored", int'(video_busy), 0);

    // R8/R9: mid-word read, deferred load, seamless reload
    do_read(4, 4);
    do_load();
    run_pix(10);
    do_read(3, 3);    // latch changes; shifter keeps row 4
    chk(video_busy, "R9 shifter kept during read", int'(video_busy), 1);
    do_load();        // deferred to the word boundary
    run_pix(54);
    chk(video_busy, "R8 no gap at boundary", int'(video_busy), 1);
    run_pix(64);
    chk(vq.size() == 0, "R8 reloaded word sent", vq.size(), 0);
    chk(!video_busy, "R7 busy falls after reload word", int'(video_busy), 0);
    chk(evq.size() == 0, "R4 all results seen", evq.size(), 0);

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule